// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Unit

This block is the software-visible side of an I2C controller. A separate bit-level engine, which is not part of this block, reports what happens on the wire as single-cycle event pulses: a start that addresses this unit for a write, a start that addresses it for a read, a stop, a missing acknowledge, a bus error, a byte that has arrived, and a request for the next byte to send. The unit turns these pulses into sticky status flags. It holds the control word, a one-byte data buffer, a 7-bit own-address register and a sampled copy of the two bus lines. It combines the flags with the enables in the control word to drive a single registered interrupt line.

Software reaches the registers through a flat byte-offset port. Writes take effect on the clock edge. Reads are combinational from the stored registers. Status flags are cleared by writing ones to them. Byte movement between the bus engine and the data buffer only happens while the unit is enabled and not held in its soft reset. The direction of the movement is chosen by the mode bit that the last start event left behind.

Top module: `i2cu_ctrl`

## Requirements
- R1: The register offsets are: 0x90 control (16 bits, read/write), 0x88 data buffer (8 bits, read/write, zero-extended on read), 0xA0 own address (7 bits stored from write data [6:0], zero-extended on read), 0x98 status, and 0x80 line monitor. The line monitor is read-only: bit 0 holds the SCL input and bit 1 holds the SDA input, each sampled on the previous clock edge. Any other offset reads as zero, and writes to it are ignored.
- R2: The interrupt output is a register. At each edge it takes the OR of four terms, using the status and control values held before that edge: (status 10 AND control 10), (status 7 AND control 9), (status 6 AND control 8), and status 9 alone.
- R3: A start-for-write pulse sets status bit 9 and clears status bit 0. A start-for-read pulse sets status bit 9 and sets status bit 0. If both arrive in the same cycle, the read outcome wins.
- R4: A stop pulse sets status bit 4. A NACK pulse sets status bit 1. A bus-error pulse sets status bit 10.
- R5: Status bits 1, 4, 6, 7, 9 and 10 are sticky and clear only when software writes a 1 to them at 0x98. An event that sets a bit in the same cycle as its clear wins. Bit 0 and the unused bits ignore status writes.
- R6: A byte transfer is ignored while control bit 14 is 1 or control bit 6 is 0. In that state a received byte changes neither the data buffer nor the status, a byte request sets no flag, and the byte output reads 0.
- R7: With the unit active and status bit 0 clear (write mode), a received byte is stored in the data buffer and sets status bit 7. In read mode a received byte is ignored.
- R8: With the unit active, the byte output presents the data buffer. A byte request in read mode (status bit 0 set) sets status bit 6. In write mode a byte request sets no flag.
- R9: Synchronous reset clears every register, every status bit and the interrupt output.
- R10: If a software write to 0x88 and an accepted received byte arrive in the same cycle, the received byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| ev_start_wr | input | 1 | Start addressed to this unit, write direction |
| ev_start_rd | input | 1 | Start addressed to this unit, read direction |
| ev_stop | input | 1 | Stop seen |
| ev_nack | input | 1 | Acknowledge missing |
| ev_bus_err | input | 1 | Bus error seen |
| rx_valid | input | 1 | A byte has arrived from the bus |
| rx_byte | input | 8 | Arrived byte |
| tx_req | input | 1 | Bus engine asks for the next byte to send |
| tx_byte | output | 8 | Byte offered to the bus engine |
| line_scl | input | 1 | Clock line level |
| line_sda | input | 1 | Data line level |
| irq | output | 1 | Interrupt request |

## Verification
Every event pulse and every register write shows up in the read data on the first sample after the edge that takes it. The interrupt follows one edge later, so an event that raises it is seen with the line still low on the first sample and high on the second. The line monitor lags its pins by one edge. The byte output is combinational from the stored data and control, so it is checked in the same sample. The bench model applies each edge's inputs to its state in the same order. It compares the outputs at every falling edge, which keeps each check exactly on the cycle where a result is due. The directed checks against constants use the same sampling point.

// File: rtl/i2cu_pkg.sv
package i2cu_pkg;

    localparam int REG_W = 16;

    localparam logic [7:0] OFS_MON  = 8'h80;
    localparam logic [7:0] OFS_DATA = 8'h88;
    localparam logic [7:0] OFS_CTRL = 8'h90;
    localparam logic [7:0] OFS_STAT = 8'h98;
    localparam logic [7:0] OFS_SAR  = 8'hA0;

    // status bit positions
    localparam int ST_MODE = 0;
    localparam int ST_NACK = 1;
    localparam int ST_STOP = 4;
    localparam int ST_TXE  = 6;
    localparam int ST_RXF  = 7;
    localparam int ST_SAD  = 9;
    localparam int ST_BERR = 10;

    // control bit positions
    localparam int CT_EN      = 6;
    localparam int CT_TXE_IE  = 8;
    localparam int CT_RXF_IE  = 9;
    localparam int CT_BERR_IE = 10;
    localparam int CT_URST    = 14;

    localparam logic [REG_W-1:0] STICKY_MASK =
        (REG_W'(1) << ST_NACK) | (REG_W'(1) << ST_STOP) | (REG_W'(1) << ST_TXE) |
        (REG_W'(1) << ST_RXF)  | (REG_W'(1) << ST_SAD)  | (REG_W'(1) << ST_BERR);

    typedef struct packed {
        logic start_wr;
        logic start_rd;
        logic stop;
        logic nack;
        logic bus_err;
        logic rx_valid;
        logic tx_req;
    } bus_ev_t;

    typedef struct packed {
        logic             wr;
        logic [7:0]       addr;
        logic [REG_W-1:0] wdata;
    } reg_req_t;

    function automatic logic unit_active(input logic [REG_W-1:0] ctrl);
        return ctrl[CT_EN] && !ctrl[CT_URST];
    endfunction

    function automatic logic irq_level(input logic [REG_W-1:0] stat,
                                       input logic [REG_W-1:0] ctrl);
        return (stat[ST_BERR] && ctrl[CT_BERR_IE]) ||
               (stat[ST_RXF]  && ctrl[CT_RXF_IE])  ||
               (stat[ST_TXE]  && ctrl[CT_TXE_IE])  ||
               stat[ST_SAD];
    endfunction

endpackage

// File: rtl/i2cu_status.sv
module i2cu_status
    import i2cu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  reg_req_t         req,
    input  logic [REG_W-1:0] ctrl,
    output logic [REG_W-1:0] stat,
    output logic             rx_take
);
    logic             xfer_ok;
    logic             tx_take;
    logic             stat_wr;
    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] clr_v;

    assign xfer_ok = unit_active(ctrl);
    assign rx_take = ev.rx_valid && xfer_ok && !stat[ST_MODE];
    assign tx_take = ev.tx_req   && xfer_ok &&  stat[ST_MODE];
    assign stat_wr = req.wr && (req.addr == OFS_STAT);

    always_comb begin
        set_v          = '0;
        set_v[ST_NACK] = ev.nack;
        set_v[ST_STOP] = ev.stop;
        set_v[ST_TXE]  = tx_take;
        set_v[ST_RXF]  = rx_take;
        set_v[ST_SAD]  = ev.start_wr || ev.start_rd;
        set_v[ST_BERR] = ev.bus_err;
        clr_v          = stat_wr ? (req.wdata & STICKY_MASK) : '0;
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (i == ST_MODE) begin : g_mode
            always_ff @(posedge clk) begin
                if (rst)
                    stat[i] <= 1'b0;
                else if (ev.start_rd)
                    stat[i] <= 1'b1;
                else if (ev.start_wr)
                    stat[i] <= 1'b0;
            end
        end else if (STICKY_MASK[i]) begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst)
                    stat[i] <= 1'b0;
                else if (set_v[i])
                    stat[i] <= 1'b1;
                else if (clr_v[i])
                    stat[i] <= 1'b0;
            end
        end else begin : g_unused
            assign stat[i] = 1'b0;
        end
    end

    AST_START_RD_MODE: assert property (@(posedge clk) disable iff (rst)
        ev.start_rd |=> (stat[ST_MODE] && stat[ST_SAD])); // R3
    AST_START_WR_MODE: assert property (@(posedge clk) disable iff (rst)
        (ev.start_wr && !ev.start_rd) |=> (!stat[ST_MODE] && stat[ST_SAD])); // R3
    AST_STOP_SETS: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> stat[ST_STOP]); // R4
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ev.start_wr || ev.start_rd) |=> $stable(stat[ST_MODE])); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stat[ST_STOP] && !(stat_wr && req.wdata[ST_STOP])) |=> stat[ST_STOP]); // R5
    AST_IDLE_NO_TXE: assert property (@(posedge clk) disable iff (rst)
        (!stat[ST_TXE] && !xfer_ok) |=> !stat[ST_TXE]); // R6

endmodule

// File: rtl/i2cu_regs.sv
module i2cu_regs
    import i2cu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SAR_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic              rx_take,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              scl,
    input  logic              sda,
    output logic [REG_W-1:0]  ctrl,
    output logic [DATA_W-1:0] data,
    output logic [SAR_W-1:0]  sar,
    output logic [1:0]        mon
);
    logic wr_ctrl;
    logic wr_data;
    logic wr_sar;

    assign wr_ctrl = req.wr && (req.addr == OFS_CTRL);
    assign wr_data = req.wr && (req.addr == OFS_DATA);
    assign wr_sar  = req.wr && (req.addr == OFS_SAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            data <= '0;
            sar  <= '0;
            mon  <= '0;
        end else begin
            mon <= {sda, scl};
            if (wr_ctrl)
                ctrl <= req.wdata;
            if (wr_sar)
                sar <= req.wdata[SAR_W-1:0];
            if (rx_take)
                data <= rx_byte;
            else if (wr_data)
                data <= req.wdata[DATA_W-1:0];
        end
    end

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rx_take && !wr_data) |=> $stable(data)); // R6
    AST_RX_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        rx_take |=> (data == $past(rx_byte))); // R10

endmodule

// File: rtl/i2cu_irq.sv
module i2cu_irq
    import i2cu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] stat,
    input  logic [REG_W-1:0] ctrl,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= irq_level(stat, ctrl);
    end

    AST_SAD_RAISES: assert property (@(posedge clk) disable iff (rst)
        stat[ST_SAD] |=> irq); // R2
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!stat[ST_SAD] && ctrl[CT_BERR_IE:CT_TXE_IE] == 3'b000) |=> !irq); // R2

endmodule

// File: rtl/i2cu_ctrl.sv
module i2cu_ctrl
    import i2cu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SAR_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ev_start_wr,
    input  logic              ev_start_rd,
    input  logic              ev_stop,
    input  logic              ev_nack,
    input  logic              ev_bus_err,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_req,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              line_scl,
    input  logic              line_sda,
    output logic              irq
);
    localparam int DPAD = REG_W - DATA_W;
    localparam int SPAD = REG_W - SAR_W;

    bus_ev_t           ev;
    reg_req_t          req;
    logic [REG_W-1:0]  ctrl;
    logic [REG_W-1:0]  stat;
    logic [DATA_W-1:0] data;
    logic [SAR_W-1:0]  sar;
    logic [1:0]        mon;
    logic              rx_take;

    assign ev = '{start_wr: ev_start_wr, start_rd: ev_start_rd, stop: ev_stop,
                  nack: ev_nack, bus_err: ev_bus_err, rx_valid: rx_valid,
                  tx_req: tx_req};
    assign req = '{wr: reg_wr, addr: 8'(reg_addr), wdata: reg_wdata};

    i2cu_regs #(.DATA_W(DATA_W), .SAR_W(SAR_W)) u_regs (
        .clk(clk), .rst(rst), .req(req), .rx_take(rx_take), .rx_byte(rx_byte),
        .scl(line_scl), .sda(line_sda), .ctrl(ctrl), .data(data), .sar(sar),
        .mon(mon)
    );

    i2cu_status u_status (
        .clk(clk), .rst(rst), .ev(ev), .req(req), .ctrl(ctrl), .stat(stat),
        .rx_take(rx_take)
    );

    i2cu_irq u_irq (
        .clk(clk), .rst(rst), .stat(stat), .ctrl(ctrl), .irq(irq)
    );

    always_comb begin
        unique case (8'(reg_addr))
            OFS_MON:  reg_rdata = {{(REG_W-2){1'b0}}, mon};
            OFS_DATA: reg_rdata = {{DPAD{1'b0}}, data};
            OFS_CTRL: reg_rdata = ctrl;
            OFS_STAT: reg_rdata = stat;
            OFS_SAR:  reg_rdata = {{SPAD{1'b0}}, sar};
            default:  reg_rdata = '0;
        endcase
    end

    assign tx_byte = unit_active(ctrl) ? data : '0;

    AST_MON_LAG: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mon == $past({line_sda, line_scl}))); // R1
    AST_TX_MUTED: assert property (@(posedge clk) disable iff (rst)
        !unit_active(ctrl) |-> (tx_byte == '0)); // R6

endmodule

// File: tb/i2cu_ctrl_bench.sv
module i2cu_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        ev_start_wr = 0, ev_start_rd = 0, ev_stop = 0, ev_nack = 0, ev_bus_err = 0;
    logic        rx_valid = 0, tx_req = 0;
    logic [7:0]  rx_byte = 8'h0;
    logic [7:0]  tx_byte;
    logic        line_scl = 0, line_sda = 0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // behavioural model state
    int m_ctrl, m_stat, m_data, m_sar, m_mon, m_irq;

    always #5 clk = ~clk;

    i2cu_ctrl u_i2cu_ctrl (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_start_wr(ev_start_wr),
        .ev_start_rd(ev_start_rd), .ev_stop(ev_stop), .ev_nack(ev_nack),
        .ev_bus_err(ev_bus_err), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .tx_byte(tx_byte), .line_scl(line_scl),
        .line_sda(line_sda), .irq(irq)
    );

    function automatic int bit_of(int v, int b);
        return (v >> b) & 1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ctrl = 0; m_stat = 0; m_data = 0; m_sar = 0; m_mon = 0; m_irq = 0;
        end else begin
            int  old_stat;
            bit  act;
            bit  rx_ok;
            old_stat = m_stat;
            act   = bit_of(m_ctrl, 6) == 1 && bit_of(m_ctrl, 14) == 0;
            m_irq = ((bit_of(old_stat, 10) & bit_of(m_ctrl, 10)) |
                     (bit_of(old_stat, 7) & bit_of(m_ctrl, 9)) |
                     (bit_of(old_stat, 6) & bit_of(m_ctrl, 8)) | bit_of(old_stat, 9));
            m_mon = {30'd0, line_sda, line_scl};
            if (reg_wr && reg_addr == 8'h98) m_stat = m_stat & ~(int'(reg_wdata) & 'h6D2);
            if (ev_start_wr) m_stat = (m_stat | 'h200) & ~1;
            if (ev_start_rd) m_stat = m_stat | 'h201;
            if (ev_stop)     m_stat = m_stat | 'h10;
            if (ev_nack)     m_stat = m_stat | 'h2;
            if (ev_bus_err)  m_stat = m_stat | 'h400;
            rx_ok = rx_valid && act && bit_of(old_stat, 0) == 0;
            if (rx_ok) m_stat = m_stat | 'h80;
            if (tx_req && act && bit_of(old_stat, 0) == 1) m_stat = m_stat | 'h40;
            if (reg_wr && reg_addr == 8'h90) m_ctrl = int'(reg_wdata);
            if (reg_wr && reg_addr == 8'hA0) m_sar = int'(reg_wdata) & 'h7F;
            if (rx_ok) m_data = int'(rx_byte);
            else if (reg_wr && reg_addr == 8'h88) m_data = int'(reg_wdata) & 'hFF;
        end
    end

    function automatic int model_read(logic [7:0] a);
        case (a)
            8'h80: return m_mon;
            8'h88: return m_data;
            8'h90: return m_ctrl;
            8'h98: return m_stat;
            8'hA0: return m_sar;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // compare all outputs with the model; called at the falling edge
    task automatic compare_all();
        int exp_tx;
        exp_tx = (bit_of(m_ctrl, 6) == 1 && bit_of(m_ctrl, 14) == 0) ? m_data : 0;
        check("R2 irq", int'(irq), m_irq);
        check("R8 tx_byte", int'(tx_byte), exp_tx);
        check("R1 reg_rdata", int'(reg_rdata), model_read(reg_addr));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (!rst) compare_all();
    endtask

    task automatic clear_inputs();
        reg_wr = 0; ev_start_wr = 0; ev_start_rd = 0; ev_stop = 0; ev_nack = 0;
        ev_bus_err = 0; rx_valid = 0; tx_req = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        tick();
        clear_inputs();
    endtask

    task automatic rd_check(string tag, logic [7:0] a, int exp);
        reg_addr = a;
        #1;
        check(tag, int'(reg_rdata), exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check("R9 irq after reset", int'(irq), 0);
        rd_check("R9 status after reset", 8'h98, 0);
        rd_check("R9 control after reset", 8'h90, 0);
        rd_check("R9 data after reset", 8'h88, 0);

        wr(8'h90, 16'h0240);
        rd_check("R1 control readback", 8'h90, 'h240);
        wr(8'hA0, 16'hFFFF);
        rd_check("R1 own address 7 bits", 8'hA0, 'h7F);
        wr(8'h84, 16'hFFFF);
        rd_check("R1 unknown offset", 8'h84, 0);
        line_scl = 1; line_sda = 0;
        tick();
        rd_check("R1 monitor lines", 8'h80, 1);

        ev_start_wr = 1; tick(); clear_inputs();
        rd_check("R3 start write status", 8'h98, 'h200);
        check("R2 irq not yet", int'(irq), 0);
        tick();
        check("R2 irq one edge later", int'(irq), 1);
        wr(8'h98, 16'h0200);
        rd_check("R5 clear by one", 8'h98, 0);
        tick();
        check("R2 irq drops", int'(irq), 0);

        rx_byte = 8'hA5; rx_valid = 1; tick(); clear_inputs();
        rd_check("R7 byte stored", 8'h88, 'hA5);
        rd_check("R7 receive flag", 8'h98, 'h80);
        tick();
        check("R2 receive irq enabled", int'(irq), 1);
        wr(8'h98, 16'hFFFF);

        wr(8'h90, 16'h0200);
        rx_byte = 8'h3C; rx_valid = 1; tx_req = 1;
        #1;
        check("R6 tx muted when disabled", int'(tx_byte), 0);
        tick(); clear_inputs();
        rd_check("R6 data unchanged disabled", 8'h88, 'hA5);
        rd_check("R6 status unchanged disabled", 8'h98, 0);
        wr(8'h90, 16'h4240);
        rx_valid = 1; tick(); clear_inputs();
        rd_check("R6 data unchanged in unit reset", 8'h88, 'hA5);

        wr(8'h90, 16'h0140);
        reg_addr = 8'h88; reg_wdata = 16'h0011; reg_wr = 1;
        rx_byte = 8'h77; rx_valid = 1; tick(); clear_inputs();
        rd_check("R10 received byte wins", 8'h88, 'h77);
        wr(8'h98, 16'hFFFF);

        ev_start_wr = 1; ev_start_rd = 1; tick(); clear_inputs();
        rd_check("R3 read wins over write", 8'h98, 'h201);
        rx_valid = 1; rx_byte = 8'h99; tick(); clear_inputs();
        rd_check("R7 receive ignored in read mode", 8'h88, 'h77);
        tx_req = 1;
        #1;
        check("R8 tx presents buffer", int'(tx_byte), 'h77);
        tick(); clear_inputs();
        rd_check("R8 transmit flag", 8'h98, 'h241);

        wr(8'h98, 16'h0001);
        rd_check("R5 mode bit read-only", 8'h98, 'h241);
        ev_stop = 1; ev_nack = 1; ev_bus_err = 1; tick(); clear_inputs();
        rd_check("R4 stop nack error flags", 8'h98, 'h653);
        reg_addr = 8'h98; reg_wdata = 16'h0010; reg_wr = 1; ev_stop = 1;
        tick(); clear_inputs();
        rd_check("R5 event wins over clear", 8'h98, 'h653);
        ev_start_wr = 1; tick(); clear_inputs();
        tx_req = 1; tick(); clear_inputs();
        rd_check("R8 no flag in write mode", 8'h98, 'h652);

        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            ev_start_wr = (r < 5);
            ev_start_rd = (r >= 5 && r < 10);
            ev_stop     = ($urandom_range(0, 15) == 0);
            ev_nack     = ($urandom_range(0, 15) == 0);
            ev_bus_err  = ($urandom_range(0, 31) == 0);
            rx_valid    = ($urandom_range(0, 5) == 0);
            rx_byte     = 8'($urandom);
            tx_req      = ($urandom_range(0, 5) == 0);
            line_scl    = 1'($urandom);
            line_sda    = 1'($urandom);
            case ($urandom_range(0, 5))
                0: reg_addr = 8'h80;
                1: reg_addr = 8'h88;
                2: reg_addr = 8'h90;
                3: reg_addr = 8'h98;
                4: reg_addr = 8'hA0;
                default: reg_addr = 8'h8C;
            endcase
            reg_wr    = ($urandom_range(0, 7) == 0);
            reg_wdata = 16'($urandom);
            if (reg_addr == 8'h90 && $urandom_range(0, 1) == 0)
                reg_wdata = (reg_wdata | 16'h0040) & 16'hBFFF;
            tick();
        end
        clear_inputs();
        tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule